// File: doc/BRIEF.md
# Dual-Output Supply Fault and Enable Supervisor

This block is the digital supervisor of a controller that produces two regulated rails: one from a synchronous buck stage and one from a linear pass device. It takes already-digitised comparator decisions (supply above its rising threshold, supply below its falling threshold, low-side over-current, buck feedback undervoltage and linear feedback undervoltage), an active-low disable pin and the completion flag of the soft-start sequencer. From these it drives a soft-start enable, one enable shared by the high-side and low-side gate drivers, an enable for the linear driver, and a three-bit latched fault status.

Both rails share one fault domain. An over-current while the rails are enabled, or an undervoltage on either feedback once the soft-start ramp has finished, shuts both rails off and holds them off. The status bits record every fault that tripped in the shutdown cycle. The latch is released only by the supply dropping below its falling threshold or by the disable pin being pulled low. Each fault comparator input is qualified by a run-length deglitch filter, so short spikes are ignored. The supply monitor applies hysteresis between its two thresholds.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: After reset the block is idle: `ss_en`, `gate_en` and `lin_en` are low and `fault_status` is 3'b000.
- R2: An internal supply-good flag sets one cycle after `sup_above_rise` is high, clears one cycle after `sup_below_fall` is high (clearing wins when both are high), and otherwise holds. From idle with `dis_n` high, soft-start begins on the clock edge after the flag is set.
- R3: While `dis_n` is low the block returns to idle on the next edge from any state, with all enables low and `fault_status` cleared, and it does not start.
- R4: `ss_en` is high only in the soft-start state. `gate_en` and `lin_en` are high in the soft-start and run states. Soft-start moves to run on the edge where `ss_done` is high.
- R5: A qualified over-current in soft-start or run enters the fault state on that edge: all enables drop and `fault_status` bit 0 is set.
- R6: A qualified buck-feedback undervoltage (status bit 1) or linear-feedback undervoltage (status bit 2) faults the block only in the run state. In soft-start both undervoltage inputs are ignored.
- R7: All faults qualified in the same cycle are recorded together in `fault_status`.
- R8: The fault state and its status are held while the supply stays good and `dis_n` stays high, whatever the fault inputs do afterwards. Loss of supply-good or `dis_n` low returns the block to idle with the status cleared.
- R9: A fault input is qualified only when it has been high for `DEGLITCH_CYC` consecutive cycles (default 2). A shorter pulse has no effect.
- R10: When a shutdown request (disable or loss of supply-good) and a qualified fault arrive in the same cycle, the shutdown wins: the block goes idle and no status is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_rise | input | 1 | Supply comparator: above rising threshold |
| sup_below_fall | input | 1 | Supply comparator: below falling threshold |
| ocp_raw | input | 1 | Low-side over-current comparator |
| sw_uv_raw | input | 1 | Buck feedback undervoltage comparator |
| lin_uv_raw | input | 1 | Linear feedback undervoltage comparator |
| dis_n | input | 1 | Active-low disable pin |
| ss_done | input | 1 | Soft-start sequencer finished |
| ss_en | output | 1 | Soft-start sequencer enable |
| gate_en | output | 1 | High-side and low-side gate driver enable |
| lin_en | output | 1 | Linear driver enable |
| fault_status | output | 3 | Latched fault causes: bit0 over-current, bit1 buck UV, bit2 linear UV |

## Verification
A wrong state register shows up at the enables on the next clock edge. A stuck fault state keeps all three enables low with a nonzero status. A missed fault leaves `gate_en` high one edge past the qualification cycle. A deglitch counter off by one trips one cycle early on a short pulse, or one cycle late, and either error shows at the enables at once. A status captured at the wrong time, or cleared by the wrong event, appears directly on `fault_status` in the cycle after the triggering input.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } pfs_state_e;

  localparam int FLT_W     = 3;
  localparam int FLT_OCP   = 0;
  localparam int FLT_SWUV  = 1;
  localparam int FLT_LINUV = 2;

  // Faults that may trip in a given state: over-current while the rails are
  // enabled, undervoltage only once the ramp has finished.
  function automatic logic [FLT_W-1:0] armed_faults(pfs_state_e s,
                                                    logic [FLT_W-1:0] q);
    logic [FLT_W-1:0] m;
    m = '0;
    case (s)
      ST_SOFT: m[FLT_OCP] = q[FLT_OCP];
      ST_RUN:  m = q;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic pfs_state_e next_state(pfs_state_e s, logic sup_ok,
                                            logic dis_n, logic ss_done,
                                            logic any_fault);
    logic stop;
    stop = !sup_ok || !dis_n;
    case (s)
      ST_IDLE:  return stop ? ST_IDLE : ST_SOFT;
      ST_SOFT:  return stop ? ST_IDLE : (any_fault ? ST_FAULT :
                                         (ss_done ? ST_RUN : ST_SOFT));
      ST_RUN:   return stop ? ST_IDLE : (any_fault ? ST_FAULT : ST_RUN);
      default:  return stop ? ST_IDLE : ST_FAULT;
    endcase
  endfunction

endpackage

// File: rtl/pfs_supply_hyst.sv
module pfs_supply_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic above_rise,
  input  logic below_fall,
  output logic sup_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sup_ok <= 1'b0;
    else if (below_fall) sup_ok <= 1'b0;
    else if (above_rise) sup_ok <= 1'b1;
  end

  AST_FALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    below_fall |=> !sup_ok); // R2
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_fall && !above_rise) |=> $stable(sup_ok)); // R2

endmodule

// File: rtl/pfs_deglitch.sv
module pfs_deglitch #(
  parameter int DEG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);

  localparam int CW = (DEG < 2) ? 1 : $clog2(DEG);
  localparam logic [CW-1:0] SAT = CW'(DEG - 1);

  logic [CW-1:0] run_len;

  // run_len counts earlier consecutive high cycles, saturating at DEG-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_len <= '0;
    else if (!raw)         run_len <= '0;
    else if (run_len != SAT) run_len <= run_len + 1'b1;
  end

  assign qual = raw && (run_len == SAT);

endmodule

// File: rtl/pfs_fault_fsm.sv
module pfs_fault_fsm
  import pfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_ok,
  input  logic             dis_n,
  input  logic             ss_done,
  input  logic [FLT_W-1:0] flt_q,
  output pfs_state_e       state,
  output logic [FLT_W-1:0] status
);

  pfs_state_e       state_nx;
  logic [FLT_W-1:0] armed;
  logic             fault_hit;
  logic             stop_req;

  assign armed     = armed_faults(state, flt_q);
  assign fault_hit = |armed;
  assign stop_req  = !sup_ok || !dis_n;
  assign state_nx  = next_state(state, sup_ok, dis_n, ss_done, fault_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      status <= '0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_FAULT) begin
        if (state != ST_FAULT) status <= armed;
      end else begin
        status <= '0;
      end
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && !stop_req) |=> (state == ST_FAULT && $stable(status))); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (state == ST_IDLE && status == '0)); // R3
  AST_UV_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOFT && !flt_q[FLT_OCP]) |=> state != ST_FAULT); // R6
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_FAULT) |-> status == '0); // R8
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && $past(state) != ST_FAULT) |-> status != '0); // R7

endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int DEGLITCH_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_above_rise,
  input  logic       sup_below_fall,
  input  logic       ocp_raw,
  input  logic       sw_uv_raw,
  input  logic       lin_uv_raw,
  input  logic       dis_n,
  input  logic       ss_done,
  output logic       ss_en,
  output logic       gate_en,
  output logic       lin_en,
  output logic [2:0] fault_status
);

  logic             sup_ok;
  logic [FLT_W-1:0] flt_raw;
  logic [FLT_W-1:0] flt_q;
  pfs_state_e       state;
  logic [FLT_W-1:0] status;

  pfs_supply_hyst u_sup (
    .clk        (clk),
    .rst_n      (rst_n),
    .above_rise (sup_above_rise),
    .below_fall (sup_below_fall),
    .sup_ok     (sup_ok)
  );

  always_comb begin
    flt_raw            = '0;
    flt_raw[FLT_OCP]   = ocp_raw;
    flt_raw[FLT_SWUV]  = sw_uv_raw;
    flt_raw[FLT_LINUV] = lin_uv_raw;
  end

  for (genvar i = 0; i < FLT_W; i++) begin : g_dg
    pfs_deglitch #(.DEG(DEGLITCH_CYC)) u_dg (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (flt_raw[i]),
      .qual  (flt_q[i])
    );
  end

  pfs_fault_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sup_ok  (sup_ok),
    .dis_n   (dis_n),
    .ss_done (ss_done),
    .flt_q   (flt_q),
    .state   (state),
    .status  (status)
  );

  assign ss_en        = (state == ST_SOFT);
  assign gate_en      = (state == ST_SOFT) || (state == ST_RUN);
  assign lin_en       = (state == ST_SOFT) || (state == ST_RUN);
  assign fault_status = status;

  AST_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status != 3'b000) |-> (!gate_en && !lin_en && !ss_en)); // R5
  AST_SS_WITH_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ss_en |-> (gate_en && lin_en)); // R4
  AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |=> (!gate_en && !lin_en)); // R3

endmodule

// File: tb/tb_pwr_fault_supervisor.sv
module tb_pwr_fault_supervisor;

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;

  localparam logic [5:0] E_IDLE = 6'b000_000;
  localparam logic [5:0] E_SS   = 6'b111_000;
  localparam logic [5:0] E_RUN  = 6'b011_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_above_rise = 1'b0, sup_below_fall = 1'b0;
  logic ocp_raw = 1'b0, sw_uv_raw = 1'b0, lin_uv_raw = 1'b0;
  logic dis_n = 1'b1, ss_done = 1'b0;
  logic ss_en, gate_en, lin_en;
  logic [2:0] fault_status;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  pwr_fault_supervisor #(.DEGLITCH_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .sup_above_rise(sup_above_rise), .sup_below_fall(sup_below_fall),
    .ocp_raw(ocp_raw), .sw_uv_raw(sw_uv_raw), .lin_uv_raw(lin_uv_raw),
    .dis_n(dis_n), .ss_done(ss_done),
    .ss_en(ss_en), .gate_en(gate_en), .lin_en(lin_en),
    .fault_status(fault_status)
  );

  function automatic logic [5:0] flt(input logic [2:0] st);
    return {3'b000, st};
  endfunction

  // driver: one clock edge, then push the state expected after it
  task automatic tick(input logic [5:0] e, input string tag);
    @(posedge clk);
    sb.push_back('{v: e, tag: tag});
    @(negedge clk);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      logic [5:0] act;
      it = sb.pop_front();
      act = {ss_en, gate_en, lin_en, fault_status};
      vectors++;
      if (act !== it.v) begin
        miscompares++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.v);
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(E_IDLE, "R1 reset state");
    // R2 power-up with hysteresis
    sup_above_rise = 1'b1;
    tick(E_IDLE, "R2 flag sets, still idle");
    sup_above_rise = 1'b0;
    tick(E_SS, "R2 soft-start begins");
    tick(E_SS, "R2 supply flag holds between thresholds");
    // R6 undervoltage ignored during soft-start
    sw_uv_raw = 1'b1; lin_uv_raw = 1'b1;
    tick(E_SS, "R6 uv blanked in soft-start");
    tick(E_SS, "R6 uv blanked in soft-start");
    tick(E_SS, "R6 uv blanked in soft-start");
    sw_uv_raw = 1'b0; lin_uv_raw = 1'b0;
    ss_done = 1'b1;
    tick(E_RUN, "R4 soft-start to run");
    // R9 short pulse ignored
    ocp_raw = 1'b1;
    tick(E_RUN, "R9 one-cycle pulse");
    ocp_raw = 1'b0;
    tick(E_RUN, "R9 pulse ignored");
    // R5 qualified over-current
    ocp_raw = 1'b1;
    tick(E_RUN, "R5 first cycle not yet qualified");
    tick(flt(3'b001), "R5 over-current fault");
    ocp_raw = 1'b0;
    tick(flt(3'b001), "R8 fault latched after input clears");
    sup_above_rise = 1'b1;
    tick(flt(3'b001), "R8 rising threshold does not clear");
    sup_above_rise = 1'b0;
    // clear by disable
    dis_n = 1'b0;
    tick(E_IDLE, "R8 disable clears fault");
    tick(E_IDLE, "R3 no start while disabled");
    dis_n = 1'b1;
    tick(E_SS, "R3 restart after release");
    tick(E_RUN, "R4 run again");
    // R6 buck undervoltage
    sw_uv_raw = 1'b1;
    tick(E_RUN, "R6 buck uv qualifying");
    tick(flt(3'b010), "R6 buck uv fault");
    sw_uv_raw = 1'b0;
    // clear by supply loss
    sup_below_fall = 1'b1;
    tick(flt(3'b010), "R8 fault held until flag drops");
    tick(E_IDLE, "R8 supply loss clears fault");
    sup_below_fall = 1'b0;
    tick(E_IDLE, "R2 flag stays low");
    sup_above_rise = 1'b1;
    tick(E_IDLE, "R2 flag sets");
    sup_above_rise = 1'b0;
    tick(E_SS, "R2 soft-start");
    tick(E_RUN, "R4 run");
    // R7 simultaneous faults
    ocp_raw = 1'b1; lin_uv_raw = 1'b1;
    tick(E_RUN, "R7 qualifying");
    tick(flt(3'b101), "R7 both causes recorded");
    ocp_raw = 1'b0; lin_uv_raw = 1'b0;
    dis_n = 1'b0;
    tick(E_IDLE, "R3 disable from fault");
    dis_n = 1'b1;
    tick(E_SS, "R4 soft-start");
    tick(E_RUN, "R4 run");
    // R6 linear undervoltage
    lin_uv_raw = 1'b1;
    tick(E_RUN, "R6 linear uv qualifying");
    tick(flt(3'b100), "R6 linear uv fault");
    lin_uv_raw = 1'b0;
    dis_n = 1'b0;
    tick(E_IDLE, "R3 disable from fault");
    dis_n = 1'b1;
    tick(E_SS, "R4 soft-start");
    tick(E_RUN, "R4 run");
    // R10 shutdown wins over coincident fault
    ocp_raw = 1'b1;
    tick(E_RUN, "R10 qualifying");
    dis_n = 1'b0;
    tick(E_IDLE, "R10 disable beats fault");
    ocp_raw = 1'b0; dis_n = 1'b1;
    tick(E_SS, "R4 soft-start");
    tick(E_RUN, "R4 run");
    // R3 disable from run
    dis_n = 1'b0;
    tick(E_IDLE, "R3 disable from run");
    dis_n = 1'b1;
    tick(E_SS, "R4 soft-start");
    tick(E_RUN, "R4 run");
    // R2 supply loss from run, falling wins over rising
    sup_below_fall = 1'b1; sup_above_rise = 1'b1;
    tick(E_RUN, "R2 flag drops this edge");
    tick(E_IDLE, "R2 supply loss stops");
    sup_below_fall = 1'b0; sup_above_rise = 1'b0;
    tick(E_IDLE, "R2 flag stayed low");
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule